// File: doc/BRIEF.md
# SPI Register-Window Slave Frontend

This block is an SPI slave for clock mode 0 that gives a host burst access to eight 32-bit register windows. Every transfer begins with a 16-bit command header. The header gives three things: the direction, the window index and a length counted in 16-bit words. The data phase follows inside the same chip-select assertion.

The serial inputs are oversampled by the system clock. Both edges of the serial clock are detected in the system-clock domain. Each completed received word raises a one-cycle write strobe into a small internal register model. On a read, transmit words are fetched from that model one halfword at a time.

A 32-bit value travels as its low halfword first and then its high halfword. Each halfword is sent most-significant byte first, so the bytes of a little-endian value appear as B1 B0 B3 B2. Transfers are always whole words. A host with an odd byte count pads it up by one byte and then halves it.

Top module: `spi_win_slave`

## Requirements
- R1: Header bit 15 selects the direction (1 = read from the block, 0 = write into it). Bits 14:12 give the window index, which is bits 4:2 of a byte address. Bits 11:0 give the transfer length in 16-bit words.
- R2: The header and the data are shifted MSB first. The block samples MOSI on rising serial-clock edges while chip-select (active low) is asserted. The header is decoded on its 16th rising edge, and the data phase starts with the next bit in the same chip-select assertion.
- R3: In a write, every completed 16-bit word produces exactly one single-cycle write strobe. The strobe carries the window, the word and a halfword index. Word k of a burst has halfword index k mod 2, where 0 selects bits 15:0 and 1 selects bits 31:16 of the window.
- R4: In a read, the first data bit is on MISO after the falling edge that follows the 16th header bit. Word k of the burst is halfword k mod 2 of the addressed window, shifted out MSB first.
- R5: A 32-bit value written as the two words V[15:0] and then V[31:16] reads back unchanged. This gives the byte order B1 B0 B3 B2.
- R6: A header with a length of zero has no data phase. Further serial clocks in the same chip-select assertion produce no strobe, and MISO stays 0.
- R7: Once the word count is used up, extra serial clocks are ignored until chip-select deasserts.
- R8: If chip-select deasserts before the count is used up, the transfer aborts. A partially shifted word is never committed, and the next assertion starts a new header.
- R9: After reset, MISO is 0, no strobe is active and every window reads 0.
- R10: MISO is 0 whenever the block is not in the data phase of a read. This includes the whole of a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idle low |
| cs_ni | input | 1 | Chip-select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| wr_valid_o | output | 1 | One-cycle strobe for a completed received word |
| wr_win_o | output | 3 | Window index of the strobed word |
| wr_half_o | output | 1 | Halfword index of the strobed word |
| wr_data_o | output | 16 | Received word |

## Verification
A header field that is captured wrong, or a count that is off by one, shows up at the ports during the same transfer. The result is a strobe with the wrong window or halfword, a missing or extra strobe, or read words that lag by a halfword. All of these are seen within 16 serial clocks of the faulty word. A wrong halfword toggle or a bad byte order shows up as a corrupted read-back of a 32-bit value written just before. A phase state that does not clear on chip-select deassertion shows up in the next transfer. That transfer either produces strobes from a stale header or drives MISO while it should be silent.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;
  parameter int HDR_W   = 16;
  parameter int WIN_W   = 3;
  parameter int WORD_W  = 16;
  parameter int REG_W   = 2 * WORD_W;
  localparam int CNT_W  = HDR_W - 1 - WIN_W;
  localparam int N_WIN  = 1 << WIN_W;
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  typedef struct packed {
    logic             rd;
    logic [WIN_W-1:0] win;
    logic [CNT_W-1:0] cnt;
  } hdr_t;
endpackage

// File: rtl/spi_win_sync.sv
module spi_win_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic active_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic              sclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= '0;
      cs_q      <= '1;
      mosi_q    <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[STAGES-2:0], sclk_i};
      cs_q      <= {cs_q[STAGES-2:0], cs_ni};
      mosi_q    <= {mosi_q[STAGES-2:0], mosi_i};
      sclk_prev <= sclk_q[STAGES-1];
    end
  end

  assign active_o = ~cs_q[STAGES-1];
  assign mosi_o   = mosi_q[STAGES-1];
  assign rise_o   = sclk_q[STAGES-1] & ~sclk_prev;
  assign fall_o   = ~sclk_q[STAGES-1] & sclk_prev;
endmodule

// File: rtl/spi_win_regs.sv
module spi_win_regs
  import spi_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIN_W-1:0]  we_win_i,
  input  logic              we_half_i,
  input  logic [WORD_W-1:0] we_data_i,
  input  logic [WIN_W-1:0]  rd_win_i,
  input  logic              rd_half_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [REG_W-1:0] win_q [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[w] <= '0;
      end else if (we_i && we_win_i == WIN_W'(w)) begin
        if (we_half_i) win_q[w][REG_W-1:WORD_W] <= we_data_i;
        else           win_q[w][WORD_W-1:0]     <= we_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = rd_half_i ? win_q[rd_win_i][REG_W-1:WORD_W]
                          : win_q[rd_win_i][WORD_W-1:0];
  end
endmodule

// File: rtl/spi_win_engine.sv
module spi_win_engine
  import spi_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              wr_valid_o,
  output logic [WIN_W-1:0]  wr_win_o,
  output logic              wr_half_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [WIN_W-1:0]  rd_win_o,
  output logic              rd_half_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  phase_e             phase_q;
  logic [BIT_W-1:0]   bit_q;
  logic [WORD_W-1:0]  rx_q, tx_q;
  logic [WORD_W-1:0]  rx_next;
  logic               rd_q, half_q, miso_q;
  logic [WIN_W-1:0]   win_q;
  logic [CNT_W-1:0]   rem_q;
  hdr_t               hdr;
  logic               last_bit;

  assign rx_next  = {rx_q[WORD_W-2:0], mosi_i};
  assign hdr      = hdr_t'(rx_next);
  assign last_bit = (bit_q == BIT_W'(WORD_W - 1));

  // Next halfword to preload: first word after header, else the other half.
  assign rd_win_o  = (phase_q == PH_HDR) ? hdr.win : win_q;
  assign rd_half_o = (phase_q == PH_HDR) ? 1'b0 : ~half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_HDR;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      rd_q       <= 1'b0;
      half_q     <= 1'b0;
      win_q      <= '0;
      rem_q      <= '0;
      miso_q     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_win_o   <= '0;
      wr_half_o  <= 1'b0;
      wr_data_o  <= '0;
    end else if (!active_i) begin
      phase_q    <= PH_HDR;
      bit_q      <= '0;
      miso_q     <= 1'b0;
      wr_valid_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      if (rise_i) begin
        unique case (phase_q)
          PH_HDR: begin
            rx_q  <= rx_next;
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              rd_q   <= hdr.rd;
              win_q  <= hdr.win;
              rem_q  <= hdr.cnt;
              half_q <= 1'b0;
              tx_q   <= rd_data_i;
              phase_q <= (hdr.cnt == '0) ? PH_DONE : PH_DATA;
            end
          end
          PH_DATA: begin
            rx_q  <= rx_next;
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              if (!rd_q) begin
                wr_valid_o <= 1'b1;
                wr_win_o   <= win_q;
                wr_half_o  <= half_q;
                wr_data_o  <= rx_next;
              end
              half_q <= ~half_q;
              rem_q  <= rem_q - 1'b1;
              tx_q   <= rd_data_i;
              if (rem_q == CNT_W'(1)) phase_q <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
      if (fall_i) begin
        if (phase_q == PH_DATA && rd_q) begin
          miso_q <= tx_q[WORD_W-1];
          tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_win_slave.sv
module spi_win_slave
  import spi_win_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              wr_valid_o,
  output logic [WIN_W-1:0]  wr_win_o,
  output logic              wr_half_o,
  output logic [WORD_W-1:0] wr_data_o
);
  logic              rise, fall, active, mosi_s;
  logic [WIN_W-1:0]  rd_win;
  logic              rd_half;
  logic [WORD_W-1:0] rd_data;

  spi_win_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .cs_ni   (cs_ni),
    .mosi_i  (mosi_i),
    .rise_o  (rise),
    .fall_o  (fall),
    .active_o(active),
    .mosi_o  (mosi_s)
  );

  spi_win_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .rise_i    (rise),
    .fall_i    (fall),
    .mosi_i    (mosi_s),
    .miso_o    (miso_o),
    .wr_valid_o(wr_valid_o),
    .wr_win_o  (wr_win_o),
    .wr_half_o (wr_half_o),
    .wr_data_o (wr_data_o),
    .rd_win_o  (rd_win),
    .rd_half_o (rd_half),
    .rd_data_i (rd_data)
  );

  spi_win_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_valid_o),
    .we_win_i (wr_win_o),
    .we_half_i(wr_half_o),
    .we_data_i(wr_data_o),
    .rd_win_i (rd_win),
    .rd_half_i(rd_half),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/spi_win_checker.sv
module spi_win_checker
  import spi_win_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             miso_o,
  input logic             wr_valid_o,
  input logic [WIN_W-1:0] wr_win_o,
  input logic             wr_half_o
);
  logic [2:0]       idle_cnt;
  logic             seen_q, last_half_q;
  logic [WIN_W-1:0] last_win_q;
  logic             quiet;

  assign quiet = (idle_cnt >= 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt    <= '0;
      seen_q      <= 1'b0;
      last_half_q <= 1'b0;
      last_win_q  <= '0;
    end else begin
      if (!cs_ni)              idle_cnt <= '0;
      else if (idle_cnt != 7)  idle_cnt <= idle_cnt + 1'b1;
      if (quiet) begin
        seen_q <= 1'b0;
      end else if (wr_valid_o) begin
        seen_q      <= 1'b1;
        last_half_q <= wr_half_o;
        last_win_q  <= wr_win_o;
      end
    end
  end

  // R10 / R8: nothing driven once chip-select has been high a while
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> (!miso_o && !wr_valid_o));

  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R3: halfword index alternates within a burst
  a_r3_half_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && seen_q && !quiet) |-> (wr_half_o != last_half_q));

  // R1: window holds for the whole burst
  a_r1_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && seen_q && !quiet) |-> (wr_win_o == last_win_q));
endmodule

bind spi_win_slave spi_win_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .wr_valid_o(wr_valid_o),
  .wr_win_o  (wr_win_o),
  .wr_half_o (wr_half_o)
);

// File: tb/spi_win_slave_tb.sv
module spi_win_slave_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_valid, wr_half;
  logic [2:0]  wr_win;
  logic [15:0] wr_data;

  always #2 clk = ~clk;

  spi_win_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .wr_valid_o(wr_valid), .wr_win_o(wr_win),
    .wr_half_o(wr_half), .wr_data_o(wr_data)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mdl [8];

  // strobe log
  int          mon_cnt = 0;
  logic [2:0]  mon_win  [256];
  logic        mon_half [256];
  logic [15:0] mon_data [256];
  always @(posedge clk) begin
    if (rst_n && wr_valid) begin
      mon_win[mon_cnt[7:0]]  <= wr_win;
      mon_half[mon_cnt[7:0]] <= wr_half;
      mon_data[mon_cnt[7:0]] <= wr_data;
      mon_cnt <= mon_cnt + 1;
    end
  end

  logic [15:0] exp_data [16];
  logic        exp_half [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] addr_to_win(input logic [7:0] addr);
    return addr[4:2];
  endfunction

  function automatic logic [15:0] mk_hdr(input bit rd, input logic [2:0] win, input int n);
    return {rd, win, 12'(n)};
  endfunction

  function automatic logic [15:0] half_of(input logic [31:0] v, input bit h);
    return h ? v[31:16] : v[15:0];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    r = miso;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic xword(input logic [15:0] w, input int nbits, output logic [15:0] r);
    logic b;
    r = '0;
    for (int i = 15; i >= 16 - nbits; i--) begin
      xbit(w[i], b);
      r[i] = b;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_off();
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(4 * HALF);
  endtask

  // Full transfer: n words, then `extra` words beyond the count.
  task automatic xfer(input bit rd, input logic [2:0] win, input int n, input int extra, input string req);
    logic [15:0] r, w;
    int base;
    base = mon_cnt;
    cs_on();
    xword(mk_hdr(rd, win, n), 16, r);
    chk(r == 16'h0, "R10 header phase miso", r, 0);
    for (int k = 0; k < n; k++) begin
      if (rd) begin
        xword(16'($urandom), 16, r);
        chk(r == half_of(mdl[win], k[0]), {req, " R4 read word"}, r, half_of(mdl[win], k[0]));
      end else begin
        w = 16'($urandom);
        xword(w, 16, r);
        chk(r == 16'h0, "R10 write phase miso", r, 0);
        if (k < 16) begin
          exp_data[k] = w;
          exp_half[k] = k[0];
        end
        if (k[0]) mdl[win][31:16] = w;
        else      mdl[win][15:0]  = w;
      end
    end
    for (int e = 0; e < extra; e++) begin
      xword(16'($urandom), 16, r);
      chk(r == 16'h0, {req, " R7 overrun miso"}, r, 0);
    end
    cs_off();
    chk(mon_cnt - base == (rd ? 0 : n), {req, " R3 strobe count"}, mon_cnt - base, rd ? 0 : n);
    if (!rd) begin
      for (int k = 0; k < n && k < 16; k++) begin
        chk(mon_win[8'(base + k)] == win, "R1 strobe window", mon_win[8'(base + k)], win);
        chk(mon_half[8'(base + k)] == exp_half[k], "R3 strobe half", mon_half[8'(base + k)], exp_half[k]);
        chk(mon_data[8'(base + k)] == exp_data[k], "R2 strobe data", mon_data[8'(base + k)], exp_data[k]);
      end
    end
  endtask

  task automatic write32(input logic [2:0] win, input logic [31:0] v);
    logic [15:0] r;
    cs_on();
    xword(mk_hdr(1'b0, win, 2), 16, r);
    xword(v[15:0], 16, r);
    xword(v[31:16], 16, r);
    cs_off();
    mdl[win] = v;
  endtask

  task automatic read32(input logic [2:0] win, output logic [31:0] v);
    logic [15:0] lo, hi;
    cs_on();
    xword(mk_hdr(1'b1, win, 2), 16, lo);
    xword(16'h0, 16, lo);
    xword(16'h0, 16, hi);
    cs_off();
    v = {hi, lo};
  endtask

  logic done = 1'b0;

  initial begin
    logic [31:0] v;
    logic [15:0] r;
    int base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    wait_clk(5);
    chk(miso == 1'b0, "R9 miso in reset", miso, 0);
    chk(wr_valid == 1'b0, "R9 strobe in reset", wr_valid, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R9: all windows zero
    for (int i = 0; i < 8; i++) begin
      read32(3'(i), v);
      chk(v == 32'h0, "R9 window reset value", v, 0);
    end

    // R1/R5: byte address 0x0C selects window 3; byte order B1 B0 B3 B2
    write32(addr_to_win(8'h0C), 32'hA1B2C3D4);
    chk(mon_data[8'(mon_cnt - 2)] == 16'hC3D4, "R5 first word low half", mon_data[8'(mon_cnt - 2)], 16'hC3D4);
    chk(mon_win[8'(mon_cnt - 1)] == 3'd3, "R1 window from address", mon_win[8'(mon_cnt - 1)], 3);
    read32(3'd3, v);
    chk(v == 32'hA1B2C3D4, "R5 read back", v, 32'hA1B2C3D4);

    // R6: zero-length header, then clocks in the same assertion
    base = mon_cnt;
    cs_on();
    xword(mk_hdr(1'b0, 3'd5, 0), 16, r);
    xword(16'hFFFF, 16, r);
    chk(r == 16'h0, "R6 zero count miso", r, 0);
    xword(16'h1234, 16, r);
    cs_off();
    chk(mon_cnt == base, "R6 zero count strobes", mon_cnt - base, 0);
    cs_on();
    xword(mk_hdr(1'b1, 3'd5, 0), 16, r);
    xword(16'h0, 16, r);
    cs_off();
    chk(r == 16'h0, "R6 zero count read miso", r, 0);

    // R7: overrun on write and read
    xfer(1'b0, 3'd2, 2, 2, "R7 write overrun");
    xfer(1'b1, 3'd2, 2, 1, "R7 read overrun");

    // R8: abort mid-word, nothing partial committed
    write32(3'd6, 32'h11112222);
    base = mon_cnt;
    cs_on();
    xword(mk_hdr(1'b0, 3'd6, 2), 16, r);
    xword(16'hAAAA, 16, r);
    xword(16'hBBBB, 9, r);
    cs_off();
    mdl[6][15:0] = 16'hAAAA;
    chk(mon_cnt - base == 1, "R8 abort strobes", mon_cnt - base, 1);
    read32(3'd6, v);
    chk(v == 32'h1111AAAA, "R8 abort no partial commit", v, 32'h1111AAAA);
    // abort during header, then a clean transfer
    cs_on();
    xword(16'h8FFF, 7, r);
    cs_off();
    read32(3'd6, v);
    chk(v == 32'h1111AAAA, "R8 new header after abort", v, 32'h1111AAAA);

    // R4: odd-length read wraps halfword back to low
    xfer(1'b1, 3'd6, 3, 0, "R4 three word read");

    // random mix
    for (int it = 0; it < 40; it++) begin
      xfer(1'($urandom), 3'($urandom), int'($urandom_range(1, 4)), int'($urandom_range(0, 1)), "R2 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule